// File: doc/BRIEF.md
# Power-up EEPROM boot selector

This block runs once after reset and decides how the device presents itself on the bus and whether code is preloaded. It reads bytes from an optional serial EEPROM through a simple byte-read request and response interface. The first byte acts as a signature. One signature value makes the block take the vendor, product and release identifiers from the EEPROM. A second value makes it copy a record-structured image into on-chip RAM through a RAM write port. Any other value, or no EEPROM at all, keeps hard-wired identifiers.

The serial bit-level master sits behind the read interface. The block passes the bus rate choice through to that master unchanged. Until the block raises its done flag, the processor is held in reset and enumeration cannot start. After that, the identifier and mode outputs stay fixed until the next reset.

Top module: `eeprom_boot_sel`

## Requirements
- R1: While reset is asserted and before the selection finishes: `cpu_hold`=1, `boot_done`=0, `ram_we`=0, and the identifier outputs show the built-in values: vendor 0x04B4, product 0x8613, release = parameter `DEF_DID` (default 0x0004).
- R2: Each read holds `ee_req` high with `ee_addr` stable until `ee_ack` or `ee_nack` is seen for one cycle. Reads start at EEPROM address 0 and advance by one per byte.
- R3: `ee_fast` always equals `cfg_fast` (1 selects 400 kbit/s, 0 selects 100 kbit/s).
- R4: Signature 0xC0 causes exactly six more reads at addresses 1..6: vendor low, vendor high, product low, product high, release low, release high. The outputs then take those values, `boot_mode`=1, and `boot_done` rises. No further reads follow.
- R5: Signature 0xC2 causes records to be read from address 1. Each record is length high, length low, RAM address high, RAM address low, then `length` data bytes. Each data byte is written in order to consecutive RAM addresses starting at the record address. The built-in identifiers are kept, and `boot_mode`=2 when the load ends.
- R6: A record whose length has bit 15 set ends the load with no data read after its four header bytes. A record of length 0 carries no data, and the next four bytes are read as a new header.
- R7: Load writes land only in 0x0000..0x1FFF and 0xE000..0xE1FF. A data byte aimed elsewhere is still read but produces no `ram_we`.
- R8: Any other signature, or a NACK on the signature read (no EEPROM), ends the selection after that single read. The result is `boot_mode`=0, built-in identifiers and `boot_err`=0.
- R9: A NACK on any read after the signature ends the selection at once. It sets `boot_err`=1 and `boot_mode`=0, restores the built-in identifiers, and issues no more reads or RAM writes.
- R10: Once `boot_done` is 1, it stays 1 and the identifiers, `boot_mode` and `boot_err` stay constant until reset. `cpu_hold` is always the inverse of `boot_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_fast | input | 1 | Serial bus rate select (1 = 400 kbit/s) |
| ee_req | output | 1 | Byte read request |
| ee_addr | output | 16 | EEPROM byte address of the request |
| ee_fast | output | 1 | Rate select passed to the serial master |
| ee_ack | input | 1 | Read completed, `ee_data` valid |
| ee_nack | input | 1 | Read failed (device absent or refused) |
| ee_data | input | 8 | Byte returned with `ee_ack` |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| id_vendor | output | 16 | Selected vendor identifier |
| id_product | output | 16 | Selected product identifier |
| id_release | output | 16 | Selected device release |
| boot_mode | output | 2 | 0 built-in, 1 EEPROM identifiers, 2 RAM load |
| boot_err | output | 1 | A read after the signature was refused |
| boot_done | output | 1 | Selection finished |
| cpu_hold | output | 1 | Processor held in reset while 1 |

## Verification
A corrupted byte pointer shows at the very next request, because `ee_addr` no longer matches the running read count. It also shows at the end of the run as a wrong total number of reads. A header or length counter that slips shows within one record: either `ram_addr` writes go to the wrong place, the number of writes is wrong, or the next header is taken from data bytes and the run stops early or late. A wrong state after a NACK or a bad signature shows as soon as `boot_done` rises, in `boot_mode`, `boot_err` and the identifier outputs, and after that as extra requests.

// File: rtl/eeboot_pkg.sv
package eeboot_pkg;
  typedef enum logic [1:0] {
    BOOT_BUILTIN  = 2'd0,
    BOOT_EE_ID    = 2'd1,
    BOOT_RAM_LOAD = 2'd2
  } boot_mode_e;

  typedef enum logic [2:0] {
    ST_SIG,
    ST_IDS,
    ST_HDR,
    ST_DATA,
    ST_DONE
  } seq_st_e;

  localparam int unsigned HDR_W = 16;
  localparam int unsigned ID_BYTES = 6;
  localparam int unsigned HDR_BYTES = 4;
endpackage

// File: rtl/eeboot_fetch.sv
module eeboot_fetch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_nack,
  input  logic [7:0]    rd_data,
  output logic          got,
  output logic          got_nack,
  output logic [7:0]    got_data
);
  logic          req_q, req_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          got_q, got_d;
  logic          nack_q, nack_d;
  logic [7:0]    data_q, data_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    got_d  = 1'b0;
    nack_d = 1'b0;
    data_d = data_q;
    if (req_q) begin
      if (rd_nack) begin
        req_d  = 1'b0;
        got_d  = 1'b1;
        nack_d = 1'b1;
      end else if (rd_ack) begin
        req_d  = 1'b0;
        got_d  = 1'b1;
        data_d = rd_data;
        addr_d = addr_q + AW'(1);
      end
    end else if (go) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      got_q  <= 1'b0;
      nack_q <= 1'b0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      got_q  <= got_d;
      nack_q <= nack_d;
      data_q <= data_d;
    end
  end

  assign busy     = req_q;
  assign rd_req   = req_q;
  assign rd_addr  = addr_q;
  assign got      = got_q;
  assign got_nack = nack_q;
  assign got_data = data_q;

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !rd_nack) |=> (rd_req && $stable(rd_addr)));

  assert_req_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (rd_ack || rd_nack)) |=> (!rd_req && got));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !rd_nack) |=> (rd_addr == $past(rd_addr) + AW'(1)));
endmodule

// File: rtl/eeboot_ram_gate.sv
module eeboot_ram_gate #(
  parameter int unsigned AW          = 16,
  parameter int unsigned CODE_BYTES  = 8192,
  parameter int unsigned SCR_BASE    = 32'hE000,
  parameter int unsigned SCR_BYTES   = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          try_we,
  input  logic [AW-1:0] try_addr,
  input  logic [7:0]    try_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata
);
  localparam logic [AW:0] CODE_LIM = (AW+1)'(CODE_BYTES);
  localparam logic [AW:0] SCR_LO   = (AW+1)'(SCR_BASE);
  localparam logic [AW:0] SCR_HI   = (AW+1)'(SCR_BASE + SCR_BYTES);

  function automatic logic in_window(input logic [AW-1:0] a);
    logic [AW:0] ax;
    ax = {1'b0, a};
    return (ax < CODE_LIM) || ((ax >= SCR_LO) && (ax < SCR_HI));
  endfunction

  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;

  always_comb begin
    we_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (try_we) begin
      we_d   = in_window(try_addr);
      addr_d = try_addr;
      data_d = try_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

  assert_we_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_addr < AW'(CODE_BYTES)) ||
                ((ram_addr >= AW'(SCR_BASE)) && (ram_addr <= AW'(SCR_BASE + SCR_BYTES - 1)))));

  assert_we_follows_try_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(try_we));
endmodule

// File: rtl/eeboot_seq.sv
module eeboot_seq
  import eeboot_pkg::*;
#(
  parameter logic [15:0] DEF_VID  = 16'h04B4,
  parameter logic [15:0] DEF_PID  = 16'h8613,
  parameter logic [15:0] DEF_DID  = 16'h0004,
  parameter logic [7:0]  SIG_IDS  = 8'hC0,
  parameter logic [7:0]  SIG_LOAD = 8'hC2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_got,
  input  logic             byte_nack,
  input  logic [7:0]       byte_data,
  input  logic             fetch_busy,
  output logic             fetch_go,
  output logic             wr_try,
  output logic [HDR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [15:0]      vid,
  output logic [15:0]      pid,
  output logic [15:0]      did,
  output boot_mode_e       mode,
  output logic             done,
  output logic             err
);
  localparam logic [2:0] ID_LAST  = 3'(ID_BYTES - 1);
  localparam logic [2:0] HDR_LAST = 3'(HDR_BYTES - 1);

  seq_st_e          st_q, st_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [47:0]      sh_q, sh_d;
  logic [HDR_W-1:0] len_q, len_d;
  logic [HDR_W-1:0] ptr_q, ptr_d;
  logic [15:0]      vid_q, vid_d, pid_q, pid_d, did_q, did_d;
  boot_mode_e       mode_q, mode_d;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic [47:0] id_cat;
  logic [31:0] hdr_cat;

  assign id_cat  = {byte_data, sh_q[47:8]};
  assign hdr_cat = {sh_q[23:0], byte_data};

  assign fetch_go = !done_q && !fetch_busy && !byte_got;
  assign wr_try   = (st_q == ST_DATA) && byte_got && !byte_nack;
  assign wr_addr  = ptr_q;
  assign wr_data  = byte_data;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    len_d  = len_q;
    ptr_d  = ptr_q;
    vid_d  = vid_q;
    pid_d  = pid_q;
    did_d  = did_q;
    mode_d = mode_q;
    done_d = done_q;
    err_d  = err_q;
    if (byte_got && !done_q) begin
      if (byte_nack) begin
        st_d   = ST_DONE;
        done_d = 1'b1;
        mode_d = BOOT_BUILTIN;
        vid_d  = DEF_VID;
        pid_d  = DEF_PID;
        did_d  = DEF_DID;
        err_d  = (st_q != ST_SIG);
      end else begin
        unique case (st_q)
          ST_SIG: begin
            cnt_d = '0;
            if (byte_data == SIG_IDS) begin
              st_d = ST_IDS;
            end else if (byte_data == SIG_LOAD) begin
              st_d = ST_HDR;
            end else begin
              st_d   = ST_DONE;
              done_d = 1'b1;
              mode_d = BOOT_BUILTIN;
            end
          end
          ST_IDS: begin
            sh_d  = id_cat;
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == ID_LAST) begin
              vid_d  = id_cat[15:0];
              pid_d  = id_cat[31:16];
              did_d  = id_cat[47:32];
              mode_d = BOOT_EE_ID;
              done_d = 1'b1;
              st_d   = ST_DONE;
            end
          end
          ST_HDR: begin
            sh_d  = {16'h0, hdr_cat};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == HDR_LAST) begin
              cnt_d = '0;
              if (hdr_cat[31]) begin
                mode_d = BOOT_RAM_LOAD;
                done_d = 1'b1;
                st_d   = ST_DONE;
              end else if (hdr_cat[30:16] != '0) begin
                len_d = hdr_cat[31:16];
                ptr_d = hdr_cat[15:0];
                st_d  = ST_DATA;
              end
            end
          end
          ST_DATA: begin
            ptr_d = ptr_q + HDR_W'(1);
            len_d = len_q - HDR_W'(1);
            if (len_q == HDR_W'(1)) begin
              st_d  = ST_HDR;
              cnt_d = '0;
            end
          end
          default: begin
            st_d = ST_DONE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SIG;
      cnt_q  <= '0;
      sh_q   <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
      vid_q  <= DEF_VID;
      pid_q  <= DEF_PID;
      did_q  <= DEF_DID;
      mode_q <= BOOT_BUILTIN;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      len_q  <= len_d;
      ptr_q  <= ptr_d;
      vid_q  <= vid_d;
      pid_q  <= pid_d;
      did_q  <= did_d;
      mode_q <= mode_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign vid  = vid_q;
  assign pid  = pid_q;
  assign did  = did_q;
  assign mode = mode_q;
  assign done = done_q;
  assign err  = err_q;

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  assert_outputs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable({vid_q, pid_q, did_q, mode_q, err_q}));

  assert_no_fetch_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!fetch_go && !wr_try));

  assert_err_builtin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mode_q == BOOT_BUILTIN && vid_q == DEF_VID && pid_q == DEF_PID && did_q == DEF_DID));

  assert_data_has_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (len_q != '0 && !len_q[HDR_W-1]));
endmodule

// File: rtl/eeprom_boot_sel.sv
module eeprom_boot_sel
  import eeboot_pkg::*;
#(
  parameter int unsigned EE_AW      = 16,
  parameter logic [15:0] DEF_VID    = 16'h04B4,
  parameter logic [15:0] DEF_PID    = 16'h8613,
  parameter logic [15:0] DEF_DID    = 16'h0004,
  parameter logic [7:0]  SIG_IDS    = 8'hC0,
  parameter logic [7:0]  SIG_LOAD   = 8'hC2,
  parameter int unsigned CODE_BYTES = 8192,
  parameter int unsigned SCR_BASE   = 32'hE000,
  parameter int unsigned SCR_BYTES  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fast,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  output logic             ee_fast,
  input  logic             ee_ack,
  input  logic             ee_nack,
  input  logic [7:0]       ee_data,
  output logic             ram_we,
  output logic [15:0]      ram_addr,
  output logic [7:0]       ram_wdata,
  output logic [15:0]      id_vendor,
  output logic [15:0]      id_product,
  output logic [15:0]      id_release,
  output logic [1:0]       boot_mode,
  output logic             boot_err,
  output logic             boot_done,
  output logic             cpu_hold
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             go, busy, got, got_nack;
  logic [7:0]       got_data;
  logic             wr_try;
  logic [HDR_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  boot_mode_e       mode;

  eeboot_fetch #(.AW(EE_AW)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .go       (go),
    .busy     (busy),
    .rd_req   (ee_req),
    .rd_addr  (ee_addr),
    .rd_ack   (ee_ack),
    .rd_nack  (ee_nack),
    .rd_data  (ee_data),
    .got      (got),
    .got_nack (got_nack),
    .got_data (got_data)
  );

  eeboot_seq #(
    .DEF_VID (DEF_VID),
    .DEF_PID (DEF_PID),
    .DEF_DID (DEF_DID),
    .SIG_IDS (SIG_IDS),
    .SIG_LOAD(SIG_LOAD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .byte_got   (got),
    .byte_nack  (got_nack),
    .byte_data  (got_data),
    .fetch_busy (busy),
    .fetch_go   (go),
    .wr_try     (wr_try),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vid        (id_vendor),
    .pid        (id_product),
    .did        (id_release),
    .mode       (mode),
    .done       (boot_done),
    .err        (boot_err)
  );

  eeboot_ram_gate #(
    .AW        (HDR_W),
    .CODE_BYTES(CODE_BYTES),
    .SCR_BASE  (SCR_BASE),
    .SCR_BYTES (SCR_BYTES)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .try_we   (wr_try),
    .try_addr (wr_addr),
    .try_data (wr_data),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata)
  );

  assign boot_mode = mode;
  assign ee_fast   = cfg_fast;
  assign cpu_hold  = !boot_done;

  assert_no_req_while_done_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (boot_done && !ee_req) |=> !ee_req);

  assert_hold_released_once_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(cpu_hold) |-> $rose(boot_done));
endmodule

// File: tb/tb_eeprom_boot_sel.sv
module tb_eeprom_boot_sel;
  localparam logic [15:0] B_VID = 16'h04B4;
  localparam logic [15:0] B_PID = 16'h8613;
  localparam logic [15:0] B_DID = 16'h0004;

  logic        clk, rst_n, cfg_fast;
  logic        ee_req, ee_fast, ee_ack, ee_nack;
  logic [15:0] ee_addr;
  logic [7:0]  ee_data;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [15:0] id_vendor, id_product, id_release;
  logic [1:0]  boot_mode;
  logic        boot_err, boot_done, cpu_hold;

  eeprom_boot_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast),
    .ee_req(ee_req), .ee_addr(ee_addr), .ee_fast(ee_fast),
    .ee_ack(ee_ack), .ee_nack(ee_nack), .ee_data(ee_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .id_vendor(id_vendor), .id_product(id_product), .id_release(id_release),
    .boot_mode(boot_mode), .boot_err(boot_err), .boot_done(boot_done),
    .cpu_hold(cpu_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  mem [0:1023];
  int          nack_at;
  int          rd_cnt;
  int          wait_cnt;
  logic [23:0] exp_wr[$];
  int          tests, fails;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM responder: sequential address check (R2), random latency
  always @(posedge clk) begin
    if (!rst_n) begin
      ee_ack <= 1'b0; ee_nack <= 1'b0; rd_cnt = 0; wait_cnt = 0;
    end else begin
      ee_ack <= 1'b0; ee_nack <= 1'b0;
      if (ee_req && !ee_ack && !ee_nack) begin
        if (wait_cnt == 0) begin
          chk(ee_addr == 16'(rd_cnt), "R2", "read address", ee_addr, 32'(rd_cnt));
          rd_cnt++;
          if (rd_cnt == nack_at) ee_nack <= 1'b1;
          else begin
            ee_ack  <= 1'b1;
            ee_data <= mem[ee_addr[9:0]];
          end
          wait_cnt = int'($urandom % 3);
        end else wait_cnt--;
      end
    end
  end

  // RAM write monitor (R5, R7)
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_wr.size() == 0)
        chk(1'b0, "R7", "unexpected ram write", {ram_addr, ram_wdata}, 0);
      else begin
        logic [23:0] e;
        e = exp_wr.pop_front();
        chk({ram_addr, ram_wdata} == e, "R5", "ram write", {ram_addr, ram_wdata}, e);
      end
    end
  end

  function automatic bit in_win(input logic [15:0] a);
    return (a <= 16'h1FFF) || (a >= 16'hE000 && a <= 16'hE1FF);
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    exp_wr.delete();
    nack_at = -1;
  endtask

  task automatic add_rec(inout int p, inout int reads, input logic [15:0] len,
                         input logic [15:0] a);
    mem[p] = len[15:8]; mem[p+1] = len[7:0]; mem[p+2] = a[15:8]; mem[p+3] = a[7:0];
    p += 4; reads += 4;
    for (int k = 0; k < int'(len); k++) begin
      logic [7:0] d;
      logic [15:0] wa;
      d = 8'($urandom);
      wa = a + 16'(k);
      mem[p] = d; p++; reads++;
      if (in_win(wa)) exp_wr.push_back({wa, d});
    end
  endtask

  task automatic add_end(inout int p, inout int reads);
    mem[p] = 8'h80; mem[p+1] = 8'h00; mem[p+2] = 8'h00; mem[p+3] = 8'h00;
    p += 4; reads += 4;
  endtask

  task automatic run_case(input string tag, input int exp_reads, input logic [1:0] exp_mode,
                          input bit exp_err, input logic [15:0] ev, input logic [15:0] ep,
                          input logic [15:0] ed);
    int guard;
    cfg_fast = 1'($urandom);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_hold == 1'b1 && boot_done == 1'b0 && ram_we == 1'b0, "R1", "reset hold/done/we",
        {cpu_hold, boot_done, ram_we}, 3'b100);
    chk({id_vendor, id_product} == {B_VID, B_PID} && id_release == B_DID, "R1", "reset ids",
        id_vendor, B_VID);
    chk(ee_fast == cfg_fast, "R3", "rate passthrough", ee_fast, cfg_fast);
    rst_n = 1'b1;
    guard = 0;
    while (!boot_done && guard < 20000) begin
      chk(cpu_hold == 1'b1, "R10", "hold before done", cpu_hold, 1);
      @(negedge clk); guard++;
    end
    chk(boot_done == 1'b1, "R10", {tag, " done rises"}, boot_done, 1);
    repeat (30) @(negedge clk);
    chk(boot_done == 1'b1 && cpu_hold == 1'b0, "R10", {tag, " done sticky"}, {boot_done, cpu_hold}, 2'b10);
    chk(boot_mode == exp_mode, tag, "boot_mode", boot_mode, exp_mode);
    chk(boot_err == exp_err, tag, "boot_err", boot_err, exp_err);
    chk(id_vendor == ev, tag, "vendor", id_vendor, ev);
    chk(id_product == ep, tag, "product", id_product, ep);
    chk(id_release == ed, tag, "release", id_release, ed);
    chk(rd_cnt == exp_reads, tag, "read count", rd_cnt, exp_reads);
    chk(exp_wr.size() == 0, tag, "missing ram writes", exp_wr.size(), 0);
    chk(ee_req == 1'b0, tag, "request idle", ee_req, 0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p, reads;
    logic [15:0] v, pr, d;
    tests = 0; fails = 0;
    void'($urandom(32'd20240));
    rst_n = 1'b0; cfg_fast = 1'b0; ee_data = '0;
    clear_img();

    // R4 directed: low byte first
    clear_img();
    mem[0] = 8'hC0; mem[1] = 8'h34; mem[2] = 8'h12; mem[3] = 8'h78;
    mem[4] = 8'h56; mem[5] = 8'hBC; mem[6] = 8'h9A; mem[7] = 8'hC2;
    run_case("R4", 7, 2'd1, 1'b0, 16'h1234, 16'h5678, 16'h9ABC);

    // R4 random identifiers
    for (int n = 0; n < 3; n++) begin
      clear_img();
      v = 16'($urandom); pr = 16'($urandom); d = 16'($urandom);
      mem[0] = 8'hC0;
      mem[1] = v[7:0]; mem[2] = v[15:8]; mem[3] = pr[7:0];
      mem[4] = pr[15:8]; mem[5] = d[7:0]; mem[6] = d[15:8];
      run_case("R4", 7, 2'd1, 1'b0, v, pr, d);
    end

    // R8 unknown signatures and absent device
    clear_img(); mem[0] = 8'hC1;
    run_case("R8", 1, 2'd0, 1'b0, B_VID, B_PID, B_DID);
    clear_img(); mem[0] = 8'h00;
    run_case("R8", 1, 2'd0, 1'b0, B_VID, B_PID, B_DID);
    clear_img(); mem[0] = 8'hC0; nack_at = 1;
    run_case("R8", 1, 2'd0, 1'b0, B_VID, B_PID, B_DID);

    // R9 nack during identifier read
    clear_img(); mem[0] = 8'hC0; mem[1] = 8'h11; mem[2] = 8'h22; nack_at = 4;
    run_case("R9", 4, 2'd0, 1'b1, B_VID, B_PID, B_DID);

    // R5 R6 R7 directed load with window edges and zero-length record
    clear_img(); mem[0] = 8'hC2; p = 1; reads = 1;
    add_rec(p, reads, 16'd3, 16'h0000);
    add_rec(p, reads, 16'd0, 16'h1234);
    add_rec(p, reads, 16'd4, 16'h1FFE);
    add_rec(p, reads, 16'd2, 16'hDFFF);
    add_rec(p, reads, 16'd2, 16'hE1FF);
    add_rec(p, reads, 16'd1, 16'hE000);
    add_end(p, reads);
    run_case("R6", reads, 2'd2, 1'b0, B_VID, B_PID, B_DID);

    // R5 R7 random loads
    for (int n = 0; n < 5; n++) begin
      int nrec;
      logic [15:0] a;
      clear_img(); mem[0] = 8'hC2; p = 1; reads = 1;
      nrec = 1 + int'($urandom % 4);
      for (int r = 0; r < nrec; r++) begin
        case ($urandom % 5)
          0: a = 16'($urandom % 16'h1FF0);
          1: a = 16'h1FFC + 16'($urandom % 4);
          2: a = 16'hE1FC + 16'($urandom % 4);
          3: a = 16'hDFFC + 16'($urandom % 4);
          default: a = 16'($urandom);
        endcase
        add_rec(p, reads, 16'($urandom % 6), a);
      end
      add_end(p, reads);
      run_case("R7", reads, 2'd2, 1'b0, B_VID, B_PID, B_DID);
    end

    // R9 nack mid-data: two bytes written, then stop
    clear_img(); mem[0] = 8'hC2; p = 1; reads = 1;
    add_rec(p, reads, 16'd5, 16'h0100);
    add_end(p, reads);
    void'(exp_wr.pop_back()); void'(exp_wr.pop_back()); void'(exp_wr.pop_back());
    nack_at = 8;
    run_case("R9", 8, 2'd0, 1'b1, B_VID, B_PID, B_DID);

    // R9 nack on header
    clear_img(); mem[0] = 8'hC2; mem[1] = 8'h00; nack_at = 3;
    run_case("R9", 3, 2'd0, 1'b1, B_VID, B_PID, B_DID);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule